// File: doc/BRIEF.md
# Flash Address Window Guard

This block decides, access by access, whether a bus read or write aimed at on-chip flash may proceed. It holds a programmable set of address windows. Each window has a start address, a length stored as its byte count less one, and a small control word with a master enable and separate read and write grants. The guard looks at every incoming access and answers allow or deny combinationally, in the same cycle. Nothing is allowed unless some enabled window covers the address and grants the kind of access requested.

Software programs the windows through a simple word-wide register port. A write window is usually opened just before a flash update by setting its write grant, and closed afterwards by clearing that grant. The start and length are not touched. The first denied access raises a sticky violation flag and latches the offending address. Both stay put until software writes a clear.

Top module: `flash_win_guard`

## Requirements
- R1: After reset every register reads zero, every window is disabled, every access is denied, and the violation flag is low.
- R2: A window covers an address when start <= address and address - start <= length register. A length register value L therefore covers L+1 bytes, and both the first and last byte are inclusive.
- R3: A covering window grants a read only if control bit 0 (enable) and bit 1 (read grant) are set. It grants a write only if bit 0 and bit 2 (write grant) are set.
- R4: A window whose enable bit is clear grants nothing, whatever its read and write grant bits hold.
- R5: Where windows overlap, an access is allowed when at least one covering window grants it.
- R6: For window i, the register byte offsets are start at 8*i, length at 8*i+4, and control at 8*N+4*i, where N is the number of windows. The status word sits at 12*N (bit 0 = violation flag) and the latched address at 12*N+4. Start and length read back as written; control reads back only bits 2:0.
- R7: Changing only the write grant bit opens or closes write access over the same range, and the start and length registers are left unchanged.
- R8: `acc_allow` follows the same-cycle inputs and is low while `acc_valid` is low. A denied valid access sets the violation flag at the next clock edge and latches its address. Later denials do not overwrite the latched address while the flag is set.
- R9: Writing 1 to status bit 0 clears the flag at the next edge. If a denied access falls in the same cycle as the clear, the flag stays set and the address of that new denial is latched.
- R10: A window that ends at the top of the address space covers its last byte without wrapping around to address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | CAW | Register byte offset (word aligned) |
| cfg_wdata | input | AW | Register write data |
| cfg_rdata | output | AW | Register read data for `cfg_addr`, combinational |
| acc_valid | input | 1 | Access present this cycle |
| acc_addr | input | AW | Access byte address |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_allow | output | 1 | Access permitted this cycle |
| viol_flag | output | 1 | Sticky violation flag |
| viol_addr | output | AW | Address of the first denied access since the last clear |

## Verification
Two events can land on the same clock edge: software clearing the violation flag, and a new denied access that sets the flag again. The bench first takes one denial and checks that its address is latched. It then drives a status clear together with a second denied access at a different address in a single cycle. The result is judged after that edge: the flag must still be high and the latched address must be the newer one. A separate check then clears with no access pending and expects the flag to drop.

// File: rtl/fwg_pkg.sv
package fwg_pkg;

    // Control word layout: bit0 enable, bit1 read grant, bit2 write grant
    typedef struct packed {
        logic wr_ok;
        logic rd_ok;
        logic on;
    } win_ctrl_t;

    localparam int unsigned CTRL_W = $bits(win_ctrl_t);

    typedef enum logic {
        ACC_RD = 1'b0,
        ACC_WR = 1'b1
    } acc_kind_t;

    // Word index helpers for the register map
    function automatic int unsigned base_word(int unsigned i);
        return 2 * i;
    endfunction

    function automatic int unsigned size_word(int unsigned i);
        return 2 * i + 1;
    endfunction

    function automatic int unsigned ctrl_word(int unsigned n, int unsigned i);
        return 2 * n + i;
    endfunction

    function automatic int unsigned stat_word(int unsigned n);
        return 3 * n;
    endfunction

    function automatic int unsigned fault_word(int unsigned n);
        return 3 * n + 1;
    endfunction

endpackage

// File: rtl/fwg_regfile.sv
module fwg_regfile
    import fwg_pkg::*;
#(
    parameter int unsigned NW  = 8,
    parameter int unsigned AW  = 32,
    parameter int unsigned CAW = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_wr,
    input  logic [CAW-1:0]          cfg_addr,
    input  logic [AW-1:0]           cfg_wdata,
    output logic [AW-1:0]           cfg_rdata,
    input  logic                    flag_i,
    input  logic [AW-1:0]           fault_addr_i,
    output logic [NW-1:0][AW-1:0]   base_o,
    output logic [NW-1:0][AW-1:0]   size_o,
    output win_ctrl_t [NW-1:0]      ctrl_o,
    output logic                    clr_o
);

    localparam int unsigned WIDX_W   = CAW - 2;
    localparam int unsigned LAST_WD  = fault_word(NW);

    initial begin
        if ((LAST_WD + 1) > (1 << WIDX_W))
            $error("fwg_regfile: CAW too small for %0d windows", NW);
    end

    logic [WIDX_W-1:0] widx;
    assign widx = cfg_addr[CAW-1:2];

    assign clr_o = cfg_wr && (int'(widx) == stat_word(NW)) && cfg_wdata[0];

    for (genvar i = 0; i < NW; i++) begin : g_win_regs
        always_ff @(posedge clk) begin
            if (rst) begin
                base_o[i] <= '0;
                size_o[i] <= '0;
                ctrl_o[i] <= '0;
            end else if (cfg_wr) begin
                if (int'(widx) == base_word(i))
                    base_o[i] <= cfg_wdata;
                if (int'(widx) == size_word(i))
                    size_o[i] <= cfg_wdata;
                if (int'(widx) == ctrl_word(NW, i))
                    ctrl_o[i] <= win_ctrl_t'(cfg_wdata[CTRL_W-1:0]);
            end
        end
    end

    always_comb begin
        cfg_rdata = '0;
        for (int i = 0; i < NW; i++) begin
            if (int'(widx) == base_word(i))
                cfg_rdata = base_o[i];
            if (int'(widx) == size_word(i))
                cfg_rdata = size_o[i];
            if (int'(widx) == ctrl_word(NW, i))
                cfg_rdata = AW'(ctrl_o[i]);
        end
        if (int'(widx) == stat_word(NW))
            cfg_rdata = AW'(flag_i);
        if (int'(widx) == fault_word(NW))
            cfg_rdata = fault_addr_i;
    end

endmodule

// File: rtl/fwg_window.sv
module fwg_window
    import fwg_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [AW-1:0] addr_i,
    input  acc_kind_t     kind_i,
    input  logic [AW-1:0] base_i,
    input  logic [AW-1:0] size_i,
    input  win_ctrl_t     ctrl_i,
    output logic          grant_o
);

    logic [AW-1:0] offset;
    logic          covers;
    logic          perm;

    // Offset from start; compared against length so no end address overflows
    assign offset = addr_i - base_i;
    assign covers = (addr_i >= base_i) && (offset <= size_i);
    assign perm   = (kind_i == ACC_WR) ? ctrl_i.wr_ok : ctrl_i.rd_ok;
    assign grant_o = ctrl_i.on && covers && perm;

endmodule

// File: rtl/fwg_fault.sv
module fwg_fault #(
    parameter int unsigned AW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          deny_i,
    input  logic [AW-1:0] addr_i,
    input  logic          clr_i,
    output logic          flag_o,
    output logic [AW-1:0] addr_o
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_o <= 1'b0;
            addr_o <= '0;
        end else if (clr_i) begin
            flag_o <= deny_i;
            if (deny_i)
                addr_o <= addr_i;
        end else if (deny_i && !flag_o) begin
            flag_o <= 1'b1;
            addr_o <= addr_i;
        end
    end

endmodule

// File: rtl/flash_win_guard.sv
module flash_win_guard
    import fwg_pkg::*;
#(
    parameter int unsigned NW  = 8,
    parameter int unsigned AW  = 32,
    parameter int unsigned CAW = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_wr,
    input  logic [CAW-1:0] cfg_addr,
    input  logic [AW-1:0]  cfg_wdata,
    output logic [AW-1:0]  cfg_rdata,
    input  logic           acc_valid,
    input  logic [AW-1:0]  acc_addr,
    input  logic           acc_write,
    output logic           acc_allow,
    output logic           viol_flag,
    output logic [AW-1:0]  viol_addr
);

    logic [NW-1:0][AW-1:0] base_q;
    logic [NW-1:0][AW-1:0] size_q;
    win_ctrl_t [NW-1:0]    ctrl_q;
    logic                  clr;
    logic [NW-1:0]         grant;
    logic                  deny;
    acc_kind_t             kind;

    assign kind = acc_write ? ACC_WR : ACC_RD;

    fwg_regfile #(.NW(NW), .AW(AW), .CAW(CAW)) u_regs (
        .clk          (clk),
        .rst          (rst),
        .cfg_wr       (cfg_wr),
        .cfg_addr     (cfg_addr),
        .cfg_wdata    (cfg_wdata),
        .cfg_rdata    (cfg_rdata),
        .flag_i       (viol_flag),
        .fault_addr_i (viol_addr),
        .base_o       (base_q),
        .size_o       (size_q),
        .ctrl_o       (ctrl_q),
        .clr_o        (clr)
    );

    for (genvar i = 0; i < NW; i++) begin : g_win
        fwg_window #(.AW(AW)) u_win (
            .addr_i  (acc_addr),
            .kind_i  (kind),
            .base_i  (base_q[i]),
            .size_i  (size_q[i]),
            .ctrl_i  (ctrl_q[i]),
            .grant_o (grant[i])
        );
    end

    assign acc_allow = acc_valid && (|grant);
    assign deny      = acc_valid && !(|grant);

    fwg_fault #(.AW(AW)) u_fault (
        .clk    (clk),
        .rst    (rst),
        .deny_i (deny),
        .addr_i (acc_addr),
        .clr_i  (clr),
        .flag_o (viol_flag),
        .addr_o (viol_addr)
    );

endmodule

// File: rtl/fwg_checker.sv
module fwg_checker #(
    parameter int unsigned NW  = 8,
    parameter int unsigned AW  = 32,
    parameter int unsigned CAW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cfg_wr,
    input logic [CAW-1:0] cfg_addr,
    input logic [AW-1:0]  cfg_wdata,
    input logic           acc_valid,
    input logic [AW-1:0]  acc_addr,
    input logic           acc_allow,
    input logic           viol_flag,
    input logic [AW-1:0]  viol_addr
);

    localparam logic [CAW-1:0] STAT_OFS = CAW'(12 * NW);

    logic sw_clear;
    logic refused;
    assign sw_clear = cfg_wr && (cfg_addr == STAT_OFS) && cfg_wdata[0];
    assign refused  = acc_valid && !acc_allow;

    // R8
    allow_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        acc_allow |-> acc_valid);

    // R8
    deny_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        refused |=> viol_flag);

    // R8
    flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !sw_clear) |=> viol_flag);

    // R8
    addr_held_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_flag && !sw_clear) |=> $stable(viol_addr));

    // R9
    clear_drops_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_clear && !refused) |=> !viol_flag);

    // R9
    clear_race_chk: assert property (@(posedge clk) disable iff (rst)
        (sw_clear && refused) |=> (viol_flag && viol_addr == $past(acc_addr)));

    // R1
    no_spurious_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (!viol_flag && !refused) |=> !viol_flag);

endmodule

bind flash_win_guard fwg_checker #(.NW(NW), .AW(AW), .CAW(CAW)) u_fwg_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .acc_valid (acc_valid),
    .acc_addr  (acc_addr),
    .acc_allow (acc_allow),
    .viol_flag (viol_flag),
    .viol_addr (viol_addr)
);

// File: tb/flash_win_guard_bench.sv
module flash_win_guard_bench;

    localparam int unsigned NW  = 8;
    localparam int unsigned AW  = 32;
    localparam int unsigned CAW = 8;
    localparam time CLK_PERIOD  = 10ns;

    localparam logic [CAW-1:0] STAT  = CAW'(12 * NW);
    localparam logic [CAW-1:0] FADDR = CAW'(12 * NW + 4);

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_wr = 1'b0;
    logic [CAW-1:0] cfg_addr = '0;
    logic [AW-1:0]  cfg_wdata = '0;
    logic [AW-1:0]  cfg_rdata;
    logic           acc_valid = 1'b0;
    logic [AW-1:0]  acc_addr = '0;
    logic           acc_write = 1'b0;
    logic           acc_allow;
    logic           viol_flag;
    logic [AW-1:0]  viol_addr;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_win_guard #(.NW(NW), .AW(AW), .CAW(CAW)) u_flash_win_guard (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .acc_valid (acc_valid),
        .acc_addr  (acc_addr),
        .acc_write (acc_write),
        .acc_allow (acc_allow),
        .viol_flag (viol_flag),
        .viol_addr (viol_addr)
    );

    function automatic logic [CAW-1:0] o_base(int i); return CAW'(8 * i);          endfunction
    function automatic logic [CAW-1:0] o_size(int i); return CAW'(8 * i + 4);      endfunction
    function automatic logic [CAW-1:0] o_ctrl(int i); return CAW'(8 * NW + 4 * i); endfunction

    task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_write(logic [CAW-1:0] a, logic [AW-1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic reg_check(string req, logic [CAW-1:0] a, logic [AW-1:0] exp);
        @(negedge clk);
        cfg_addr = a;
        #1;
        check(req, cfg_rdata, exp, $sformatf("readback @%h", a));
    endtask

    // One access cycle; allow sampled before the edge
    task automatic probe(string req, logic [AW-1:0] a, logic wr, logic exp);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_write = wr;
        #1;
        check(req, AW'(acc_allow), AW'(exp), $sformatf("allow %s @%h", wr ? "wr" : "rd", a));
        @(negedge clk);
        acc_valid = 1'b0;
    endtask

    task automatic clear_flag();
        reg_write(STAT, 32'h1);
    endtask

    task automatic t_reset();
        reg_check("R1", o_base(0), '0);
        reg_check("R1", o_size(NW - 1), '0);
        reg_check("R1", o_ctrl(3), '0);
        reg_check("R1", STAT, '0);
        check("R1", AW'(viol_flag), 0, "flag after reset");
        probe("R1", 32'h0, 1'b0, 1'b0);
        probe("R1", 32'h0, 1'b1, 1'b0);
    endtask

    task automatic t_map();
        reg_write(o_base(1), 32'h0000_1000);
        reg_write(o_size(1), 32'h0000_00FF);
        reg_write(o_ctrl(1), 32'h0000_000F);
        reg_check("R6", o_base(1), 32'h0000_1000);
        reg_check("R6", o_size(1), 32'h0000_00FF);
        reg_check("R6", o_ctrl(1), 32'h0000_0007);
        reg_check("R6", o_base(2), '0);
    endtask

    task automatic t_bounds();
        reg_write(o_ctrl(1), 32'h3);
        probe("R2", 32'h0000_1000, 1'b0, 1'b1);
        probe("R2", 32'h0000_10FF, 1'b0, 1'b1);
        probe("R2", 32'h0000_1100, 1'b0, 1'b0);
        probe("R2", 32'h0000_0FFF, 1'b0, 1'b0);
    endtask

    task automatic t_perm();
        probe("R3", 32'h0000_1010, 1'b1, 1'b0);
        reg_write(o_ctrl(1), 32'h5);
        probe("R3", 32'h0000_1010, 1'b1, 1'b1);
        probe("R3", 32'h0000_1010, 1'b0, 1'b0);
        reg_write(o_ctrl(1), 32'h6);
        probe("R4", 32'h0000_1010, 1'b0, 1'b0);
        probe("R4", 32'h0000_1010, 1'b1, 1'b0);
    endtask

    task automatic t_overlap();
        reg_write(o_base(2), 32'h0000_1080);
        reg_write(o_size(2), 32'h0000_007F);
        reg_write(o_ctrl(2), 32'h5);
        reg_write(o_ctrl(1), 32'h3);
        probe("R5", 32'h0000_1090, 1'b0, 1'b1);
        probe("R5", 32'h0000_1090, 1'b1, 1'b1);
        probe("R5", 32'h0000_1010, 1'b1, 1'b0);
        reg_write(o_ctrl(2), 32'h0);
    endtask

    task automatic t_toggle();
        reg_write(o_ctrl(1), 32'h7);
        probe("R7", 32'h0000_1020, 1'b1, 1'b1);
        reg_write(o_ctrl(1), 32'h3);
        probe("R7", 32'h0000_1020, 1'b1, 1'b0);
        probe("R7", 32'h0000_1020, 1'b0, 1'b1);
        reg_check("R7", o_base(1), 32'h0000_1000);
        reg_check("R7", o_size(1), 32'h0000_00FF);
    endtask

    task automatic t_top();
        reg_write(o_base(0), 32'hFFFF_F000);
        reg_write(o_size(0), 32'h0000_0FFF);
        reg_write(o_ctrl(0), 32'h3);
        probe("R10", 32'hFFFF_FFFF, 1'b0, 1'b1);
        probe("R10", 32'hFFFF_F000, 1'b0, 1'b1);
        probe("R10", 32'h0000_0000, 1'b0, 1'b0);
    endtask

    task automatic t_fault();
        clear_flag();
        @(negedge clk);
        check("R9", AW'(viol_flag), 0, "flag after clear");
        acc_valid = 1'b0; acc_addr = 32'h0000_2222;
        #1;
        check("R8", AW'(acc_allow), 0, "allow with valid low");
        @(negedge clk);
        check("R8", AW'(viol_flag), 0, "no flag when idle");
        probe("R8", 32'h0000_1004, 1'b0, 1'b1);
        check("R8", AW'(viol_flag), 0, "allowed access leaves flag low");
        probe("R8", 32'h0000_2222, 1'b1, 1'b0);
        check("R8", AW'(viol_flag), 1, "flag after denial");
        check("R8", viol_addr, 32'h0000_2222, "latched address");
        reg_check("R8", STAT, 32'h1);
        reg_check("R8", FADDR, 32'h0000_2222);
        probe("R8", 32'h0000_3333, 1'b1, 1'b0);
        check("R8", viol_addr, 32'h0000_2222, "address kept on second denial");
        clear_flag();
        check("R9", AW'(viol_flag), 0, "flag cleared");
        probe("R9", 32'h0000_4444, 1'b1, 1'b0);
        // clear and new denial in the same cycle
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = STAT; cfg_wdata = 32'h1;
        acc_valid = 1'b1; acc_addr = 32'h0000_5555; acc_write = 1'b0;
        @(negedge clk);
        cfg_wr = 1'b0; acc_valid = 1'b0;
        check("R9", AW'(viol_flag), 1, "flag after clear+denial");
        check("R9", viol_addr, 32'h0000_5555, "address after clear+denial");
        clear_flag();
        check("R9", AW'(viol_flag), 0, "flag after plain clear");
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_map();
        t_bounds();
        t_perm();
        t_overlap();
        t_toggle();
        t_top();
        t_fault();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule